// File: doc/BRIEF.md
# Microcode Control Sequencer

This block drives the control lines of a multi-cycle datapath from a writable control store instead of from hardwired next-state logic. A micro-program counter (micro-PC) selects one microword per step. Each microword carries one bit per datapath control line plus a two-bit sequencing code. The code tells the sequencer whether to step to the following address, to branch through an opcode-indexed dispatch table, or to end the instruction and return to the fetch address.

By convention the microcode places the fetch microword at address 0 and the decode microword, which carries the dispatch code, at address 1. Every instruction therefore runs fetch, then decode, then its own routine, and ends with a microword whose code is "done". Microcode and dispatch entries are loaded through a valid/ready write port. That port only accepts writes while the halt input is held, so a running program can never be altered under its own feet.

The control word leaves on a valid/ready stream. The datapath lowers `ctrl_ready` to stretch a step, for example to wait on memory. While `ctrl_valid` is high and `ctrl_ready` is low, the word on `ctrl_data` and the micro-PC are held unchanged. The loader port follows the usual rule: a write transfers in a cycle where both `ld_valid` and `ld_ready` are high. A sender that sees `ld_ready` low must keep its offer or withdraw it. The offer itself changes nothing.

Top module: `useq_top`

## Requirements
- R1: A synchronous active-high reset sets the micro-PC to 0 and clears every control-store word and every dispatch entry to zero.
- R2: A control-store word is laid out with the sequencing code in bits [CTRL_W+1:CTRL_W] and the control bits in [CTRL_W-1:0]. While not halted, `ctrl_valid` is 1 and `ctrl_data` shows the control bits of the word at the micro-PC.
- R3: Sequencing code 2'b00 (step) moves the micro-PC to its own value plus one, wrapping modulo 2^UADDR_W, when the word is accepted.
- R4: Sequencing code 2'b01 (dispatch) moves the micro-PC to the dispatch entry indexed by `opcode` as sampled in the accepting cycle. An opcode that was never loaded maps to 0.
- R5: Sequencing codes 2'b10 and 2'b11 (done) return the micro-PC to 0 on acceptance. `instr_done` is 1 while such a word is presented.
- R6: While `ctrl_valid` is 1 and `ctrl_ready` is 0, the micro-PC and `ctrl_data` do not change, and the opcode is not sampled.
- R7: While `halt` is 1, `ctrl_valid`, `ctrl_data` and `instr_done` are 0 and the micro-PC holds its value.
- R8: `ld_ready` equals `halt`. A transfer with `ld_sel`=0 writes `ld_data` to store word `ld_addr`. A transfer with `ld_sel`=1 writes the low UADDR_W bits of `ld_data` to dispatch entry `ld_addr`. An offer made while running writes nothing.
- R9: A word written into the store at the current micro-PC appears on `ctrl_data` in the first cycle after the write in which the sequencer is not halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| halt | input | 1 | Freezes sequencing and opens the loader |
| opcode | input | OPC_W | Instruction opcode used by dispatch |
| ctrl_valid | output | 1 | Control word is being presented |
| ctrl_ready | input | 1 | Datapath accepts the current control word |
| ctrl_data | output | CTRL_W | Datapath control lines |
| instr_done | output | 1 | Current word ends the instruction |
| upc | output | UADDR_W | Current micro-PC |
| ld_valid | input | 1 | Loader write offered |
| ld_ready | output | 1 | Loader write can be taken |
| ld_sel | input | 1 | 0 = control store, 1 = dispatch table |
| ld_addr | input | LD_AW | Word or opcode index to write |
| ld_data | input | CTRL_W+2 | Microword, or target address in low bits |

## Verification
Loading and sequencing compete for the same cycles. A writer may present `ld_valid` continuously while `halt` toggles, and the micro-PC must never move in a cycle where a write lands. The bench holds a write offer across a running stall and then raises `halt` with the offer still present. It judges the result by whether the microword at the live micro-PC stays put while running and shows the new value on the first unhalted cycle. A second overlap is a stall on the decode word while the opcode changes. Here the dispatch must follow the opcode present in the accepting cycle and ignore the one present during the stall.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int SEQ_W = 2;

  typedef enum logic [SEQ_W-1:0] {
    SEQ_STEP  = 2'b00,
    SEQ_DISP  = 2'b01,
    SEQ_END   = 2'b10,
    SEQ_END_B = 2'b11
  } seq_e;

  function automatic logic seq_is_end(seq_e s);
    return (s == SEQ_END) || (s == SEQ_END_B);
  endfunction
endpackage

// File: rtl/useq_ram.sv
module useq_ram #(
  parameter int W  = 18,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/useq_loader.sv
module useq_loader (
  input  logic halt,
  input  logic ld_valid,
  input  logic ld_sel,
  output logic ld_ready,
  output logic store_we,
  output logic table_we
);
  logic xfer;

  assign ld_ready = halt;
  assign xfer     = ld_valid && ld_ready;
  assign store_we = xfer && !ld_sel;
  assign table_we = xfer && ld_sel;
endmodule

// File: rtl/useq_nextpc.sv
module useq_nextpc
  import useq_pkg::*;
#(
  parameter int UADDR_W    = 6,
  parameter int FETCH_ADDR = 0
) (
  input  logic [UADDR_W-1:0] cur,
  input  seq_e               seq,
  input  logic [UADDR_W-1:0] disp_tgt,
  output logic [UADDR_W-1:0] nxt
);
  always_comb begin
    unique case (seq)
      SEQ_STEP: nxt = cur + 1'b1;
      SEQ_DISP: nxt = disp_tgt;
      default:  nxt = UADDR_W'(FETCH_ADDR);
    endcase
  end
endmodule

// File: rtl/useq_top.sv
module useq_top
  import useq_pkg::*;
#(
  parameter int CTRL_W     = 16,
  parameter int UADDR_W    = 6,
  parameter int OPC_W      = 6,
  parameter int FETCH_ADDR = 0,
  localparam int LD_AW     = (UADDR_W > OPC_W) ? UADDR_W : OPC_W,
  localparam int WORD_W    = CTRL_W + SEQ_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               halt,
  input  logic [OPC_W-1:0]   opcode,
  output logic               ctrl_valid,
  input  logic               ctrl_ready,
  output logic [CTRL_W-1:0]  ctrl_data,
  output logic               instr_done,
  output logic [UADDR_W-1:0] upc,
  input  logic               ld_valid,
  output logic               ld_ready,
  input  logic               ld_sel,
  input  logic [LD_AW-1:0]   ld_addr,
  input  logic [WORD_W-1:0]  ld_data
);
  logic [UADDR_W-1:0] upc_q;
  logic [UADDR_W-1:0] upc_nxt;
  logic [UADDR_W-1:0] disp_tgt;
  logic [WORD_W-1:0]  cur_word;
  logic [CTRL_W-1:0]  cur_ctrl;
  seq_e               cur_seq;
  logic               store_we;
  logic               table_we;
  logic               step;

  useq_loader u_loader (
    .halt     (halt),
    .ld_valid (ld_valid),
    .ld_sel   (ld_sel),
    .ld_ready (ld_ready),
    .store_we (store_we),
    .table_we (table_we)
  );

  useq_ram #(.W(WORD_W), .AW(UADDR_W)) u_store (
    .clk   (clk),
    .rst   (rst),
    .we    (store_we),
    .waddr (ld_addr[UADDR_W-1:0]),
    .wdata (ld_data),
    .raddr (upc_q),
    .rdata (cur_word)
  );

  useq_ram #(.W(UADDR_W), .AW(OPC_W)) u_disp (
    .clk   (clk),
    .rst   (rst),
    .we    (table_we),
    .waddr (ld_addr[OPC_W-1:0]),
    .wdata (ld_data[UADDR_W-1:0]),
    .raddr (opcode),
    .rdata (disp_tgt)
  );

  assign cur_ctrl = cur_word[CTRL_W-1:0];
  assign cur_seq  = seq_e'(cur_word[CTRL_W +: SEQ_W]);

  useq_nextpc #(.UADDR_W(UADDR_W), .FETCH_ADDR(FETCH_ADDR)) u_nextpc (
    .cur      (upc_q),
    .seq      (cur_seq),
    .disp_tgt (disp_tgt),
    .nxt      (upc_nxt)
  );

  assign ctrl_valid = !halt;
  assign step       = ctrl_valid && ctrl_ready;

  always_ff @(posedge clk) begin
    if (rst)       upc_q <= UADDR_W'(FETCH_ADDR);
    else if (step) upc_q <= upc_nxt;
  end

  assign ctrl_data  = halt ? '0 : cur_ctrl;
  assign instr_done = !halt && seq_is_end(cur_seq);
  assign upc        = upc_q;
endmodule

// File: rtl/useq_top_chk.sv
module useq_top_chk
  import useq_pkg::*;
#(
  parameter int CTRL_W     = 16,
  parameter int UADDR_W    = 6,
  parameter int FETCH_ADDR = 0
) (
  input logic               clk,
  input logic               rst,
  input logic               halt,
  input logic               ctrl_valid,
  input logic               ctrl_ready,
  input logic [CTRL_W-1:0]  ctrl_data,
  input logic               instr_done,
  input logic [UADDR_W-1:0] upc,
  input logic               ld_ready,
  input seq_e               cur_seq
);
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (rst)
    halt |-> (!ctrl_valid && ctrl_data == '0 && !instr_done)); // R7

  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (rst)
    halt |=> (upc == $past(upc))); // R7

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ctrl_valid && !ctrl_ready) |=> (upc == $past(upc))); // R6

  AST_STEP_INC: assert property (@(posedge clk) disable iff (rst)
    (ctrl_valid && ctrl_ready && cur_seq == SEQ_STEP) |=> (upc == $past(upc) + 1'b1)); // R3

  AST_END_FETCH: assert property (@(posedge clk) disable iff (rst)
    (ctrl_valid && ctrl_ready && instr_done) |=> (upc == UADDR_W'(FETCH_ADDR))); // R5

  AST_LOAD_GATE: assert property (@(posedge clk) disable iff (rst)
    ld_ready == halt); // R8
endmodule

bind useq_top useq_top_chk #(
  .CTRL_W     (CTRL_W),
  .UADDR_W    (UADDR_W),
  .FETCH_ADDR (FETCH_ADDR)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .halt       (halt),
  .ctrl_valid (ctrl_valid),
  .ctrl_ready (ctrl_ready),
  .ctrl_data  (ctrl_data),
  .instr_done (instr_done),
  .upc        (upc),
  .ld_ready   (ld_ready),
  .cur_seq    (cur_seq)
);

// File: tb/useq_top_tb_top.sv
module useq_top_tb_top;
  localparam int CTRL_W  = 16;
  localparam int UADDR_W = 6;
  localparam int OPC_W   = 6;
  localparam int WORD_W  = CTRL_W + 2;
  localparam int NVEC    = 27;

  logic               clk = 1'b0;
  logic               rst;
  logic               halt;
  logic [OPC_W-1:0]   opcode;
  logic               ctrl_valid;
  logic               ctrl_ready;
  logic [CTRL_W-1:0]  ctrl_data;
  logic               instr_done;
  logic [UADDR_W-1:0] upc;
  logic               ld_valid;
  logic               ld_ready;
  logic               ld_sel;
  logic [5:0]         ld_addr;
  logic [WORD_W-1:0]  ld_data;

  int checks   = 0;
  int failures = 0;

  always #4 clk = ~clk;

  useq_top dut_i (
    .clk(clk), .rst(rst), .halt(halt), .opcode(opcode),
    .ctrl_valid(ctrl_valid), .ctrl_ready(ctrl_ready), .ctrl_data(ctrl_data),
    .instr_done(instr_done), .upc(upc), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_sel(ld_sel), .ld_addr(ld_addr), .ld_data(ld_data)
  );

  // {opcode, ctrl_ready, expected upc, expected ctrl_data, expected instr_done}
  localparam logic [29:0] VEC [NVEC] = '{
    {6'd0,  1'b1, 6'd0,  16'h0001, 1'b0},
    {6'd0,  1'b1, 6'd1,  16'h0002, 1'b0},
    {6'd0,  1'b1, 6'd8,  16'h0010, 1'b0},
    {6'd0,  1'b1, 6'd9,  16'h0020, 1'b1},
    {6'd35, 1'b1, 6'd0,  16'h0001, 1'b0},
    {6'd35, 1'b1, 6'd1,  16'h0002, 1'b0},
    {6'd35, 1'b0, 6'd16, 16'h0100, 1'b0},
    {6'd35, 1'b1, 6'd16, 16'h0100, 1'b0},
    {6'd35, 1'b1, 6'd17, 16'h0200, 1'b0},
    {6'd35, 1'b1, 6'd18, 16'h0400, 1'b1},
    {6'd4,  1'b1, 6'd0,  16'h0001, 1'b0},
    {6'd4,  1'b1, 6'd1,  16'h0002, 1'b0},
    {6'd4,  1'b1, 6'd24, 16'h1000, 1'b1},
    {6'd63, 1'b1, 6'd0,  16'h0001, 1'b0},
    {6'd63, 1'b1, 6'd1,  16'h0002, 1'b0},
    {6'd63, 1'b1, 6'd63, 16'h8000, 1'b0},
    {6'd5,  1'b1, 6'd0,  16'h0001, 1'b0},
    {6'd5,  1'b1, 6'd1,  16'h0002, 1'b0},
    {6'd4,  1'b1, 6'd0,  16'h0001, 1'b0},
    {6'd4,  1'b0, 6'd1,  16'h0002, 1'b0},
    {6'd0,  1'b1, 6'd1,  16'h0002, 1'b0},
    {6'd0,  1'b1, 6'd8,  16'h0010, 1'b0},
    {6'd0,  1'b1, 6'd9,  16'h0020, 1'b1},
    {6'd7,  1'b1, 6'd0,  16'h0001, 1'b0},
    {6'd7,  1'b1, 6'd1,  16'h0002, 1'b0},
    {6'd7,  1'b1, 6'd40, 16'h0F00, 1'b1},
    {6'd7,  1'b1, 6'd0,  16'h0001, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a falling edge, returns at a falling edge
  task automatic load(input logic sel, input logic [5:0] addr, input logic [WORD_W-1:0] data);
    ld_valid = 1'b1; ld_sel = sel; ld_addr = addr; ld_data = data;
    @(posedge clk);
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1'b1; halt = 1'b0; opcode = '0; ctrl_ready = 1'b0;
    ld_valid = 1'b0; ld_sel = 1'b0; ld_addr = '0; ld_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    chk("R1 upc after reset", 32'(upc), 0);
    chk("R1 cleared word", 32'(ctrl_data), 0);
    chk("R8 ld_ready running", 32'(ld_ready), 0);
    rst = 1'b0;
    halt = 1'b1;
    #1;
    chk("R7 valid low", 32'(ctrl_valid), 0);
    chk("R8 ld_ready halted", 32'(ld_ready), 1);
    load(1'b0, 6'd0,  {2'b00, 16'h0001});
    load(1'b0, 6'd1,  {2'b01, 16'h0002});
    load(1'b0, 6'd8,  {2'b00, 16'h0010});
    load(1'b0, 6'd9,  {2'b10, 16'h0020});
    load(1'b0, 6'd16, {2'b00, 16'h0100});
    load(1'b0, 6'd17, {2'b00, 16'h0200});
    load(1'b0, 6'd18, {2'b10, 16'h0400});
    load(1'b0, 6'd24, {2'b10, 16'h1000});
    load(1'b0, 6'd40, {2'b11, 16'h0F00});
    load(1'b0, 6'd63, {2'b00, 16'h8000});
    load(1'b1, 6'd0,  18'd8);
    load(1'b1, 6'd35, 18'd16);
    load(1'b1, 6'd4,  18'd24);
    load(1'b1, 6'd63, 18'd63);
    load(1'b1, 6'd7,  18'd40);
    #1;
    chk("R7 upc held while halted", 32'(upc), 0);
    halt = 1'b0;

    // R2 R3 R4 R5 R6: microprogram walk
    for (int i = 0; i < NVEC; i++) begin
      opcode     = VEC[i][29:24];
      ctrl_ready = VEC[i][23];
      #1;
      chk($sformatf("R2/R3/R4/R6 upc vec %0d", i), 32'(upc), 32'(VEC[i][22:17]));
      chk($sformatf("R2 ctrl vec %0d", i), 32'(ctrl_data), 32'(VEC[i][16:1]));
      chk($sformatf("R5 done vec %0d", i), 32'(instr_done), 32'(VEC[i][0]));
      @(posedge clk);
      @(negedge clk);
    end

    // R8: write offered while running (stalled at upc 1) is not taken
    ctrl_ready = 1'b0;
    ld_valid = 1'b1; ld_sel = 1'b0; ld_addr = 6'd1; ld_data = {2'b00, 16'hDEAD};
    #1;
    chk("R8 ld_ready low running", 32'(ld_ready), 0);
    chk("R6 stalled word", 32'(ctrl_data), 32'h0002);
    @(posedge clk);
    @(negedge clk);
    #1;
    chk("R8 running write ignored", 32'(ctrl_data), 32'h0002);
    halt = 1'b1;
    #1;
    chk("R7 ctrl zero when halted", 32'(ctrl_data), 0);
    chk("R7 done low when halted", 32'(instr_done), 0);
    @(posedge clk);
    @(negedge clk);
    ld_valid = 1'b0;
    halt = 1'b0;
    #1;
    chk("R9 new word visible", 32'(ctrl_data), 32'hDEAD);
    chk("R7 upc kept through halt", 32'(upc), 1);
    ctrl_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    #1;
    chk("R3 rewritten word steps", 32'(upc), 2);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1 upc after midrun reset", 32'(upc), 0);
    chk("R1 store cleared", 32'(ctrl_data), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule